// File: doc/BRIEF.md
# Dual-Address Slave Address Matcher

This block decides whether a two-wire bus slave acknowledges the address phase of a transfer. The byte received after a START holds a 7-bit address in its upper bits and the read/write direction in bit 0. The block compares that address with a primary own address, which is always active. When the alternate-enable bit is set, it also compares the address with a second, alternate address. Two independent comparators feed a single acknowledge decision.

A registered status bit records whether the address that was acknowledged is the alternate one. If both comparators hit, the primary address wins. The decision is captured on the address-valid strobe and then held until the next START or a reset. The shift register that assembles the byte from the bus, and the rest of the slave data path, sit outside this block.

Top module: `dual_addr_match`

## Requirements
- R1: After a synchronous reset, `ack_o`, `match_o`, `rd_nwr_o` and `alt_sel_o` are all 0.
- R2: The edge that samples `addr_vld_i` high updates the outputs. When `alt_en_i` is 0, `ack_o` from that edge on is 1 exactly when `addr_byte_i[7:1]` equals `own_addr_i`. The value of `alt_addr_i` then has no effect.
- R3: When `alt_en_i` is 1, `ack_o` after the strobe is 1 when `addr_byte_i[7:1]` equals either `own_addr_i` or `alt_addr_i`, and 0 otherwise.
- R4: `alt_sel_o` after the strobe is 1 only under all three of these conditions: `alt_en_i` is 1, the address equals `alt_addr_i`, and the address does not equal `own_addr_i`.
- R5: `alt_sel_o` is 0 after a strobe where the primary address matched, including the case where both addresses are equal and enabled. It is also 0 after a strobe where nothing matched.
- R6: `rd_nwr_o` takes the value of `addr_byte_i[0]` on every strobe, whether or not the address matched.
- R7: `match_o` is 1 for exactly the one cycle after a strobe that produced an acknowledge. It is 0 at all other times.
- R8: Without a strobe, `ack_o`, `alt_sel_o` and `rd_nwr_o` hold their values. A `start_i` pulse without a strobe clears all three to 0. If `start_i` and `addr_vld_i` arrive in the same cycle, the strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START condition seen; clears the held decision |
| addr_vld_i | input | 1 | One-cycle strobe: `addr_byte_i` holds a complete address byte |
| addr_byte_i | input | 8 | Received byte: address in [7:1], read/write in [0] |
| own_addr_i | input | 7 | Primary own address, always compared |
| alt_addr_i | input | 7 | Alternate address |
| alt_en_i | input | 1 | Enables the alternate comparison |
| ack_o | output | 1 | Acknowledge decision for the address phase |
| match_o | output | 1 | One-cycle pulse after an acknowledged address |
| rd_nwr_o | output | 1 | Captured direction bit (1 = read) |
| alt_sel_o | output | 1 | The acknowledged address was the alternate one |

## Verification
All 256 received byte values are swept against four register setups:
- **Distinct addresses, alternate disabled.** A byte that hits only the alternate must be refused, which shows that the enable gates the second comparator.
- **Same addresses, alternate enabled.** This splits the primary hits from the alternate hits and also shows the bytes that hit neither.
- **Equal addresses, both enabled.** This exposes the primary-first priority in `alt_sel_o`.
- **Addresses 0x00 and 0x7F.** These catch off-by-one errors and dropped bits at the edges of the address field.

After each strobe, the bench checks the pulse, the hold cycle and the START clear. That shows whether the captured state lasts for the right span. A START that coincides with a strobe is checked separately.

// File: rtl/dual_addr_match_pkg.sv
package dual_addr_match_pkg;

  typedef struct packed {
    logic ack;
    logic alt_sel;
  } match_res_t;

endpackage

// File: rtl/addr_cmp.sv
module addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              slot_en,
  output logic              hit
);

  always_comb begin
    hit = slot_en && (rx_addr == slot_addr);
  end

endmodule

// File: rtl/match_arbiter.sv
module match_arbiter
  import dual_addr_match_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic [NSLOT-1:0] hits,
  output match_res_t       res
);

  // Slot 0 is the primary address and always wins over the others.
  always_comb begin
    res.ack     = |hits;
    res.alt_sel = !hits[0] && (|hits[NSLOT-1:1]);
  end

endmodule

// File: rtl/match_regs.sv
module match_regs
  import dual_addr_match_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       vld_i,
  input  match_res_t res_i,
  input  logic       dir_i,
  output logic       ack_o,
  output logic       match_o,
  output logic       rd_nwr_o,
  output logic       alt_sel_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o     <= 1'b0;
      match_o   <= 1'b0;
      rd_nwr_o  <= 1'b0;
      alt_sel_o <= 1'b0;
    end else if (vld_i) begin
      ack_o     <= res_i.ack;
      match_o   <= res_i.ack;
      rd_nwr_o  <= dir_i;
      alt_sel_o <= res_i.alt_sel;
    end else if (start_i) begin
      ack_o     <= 1'b0;
      match_o   <= 1'b0;
      rd_nwr_o  <= 1'b0;
      alt_sel_o <= 1'b0;
    end else begin
      match_o   <= 1'b0;
    end
  end

endmodule

// File: rtl/dual_addr_match.sv
module dual_addr_match
  import dual_addr_match_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W:0]   addr_byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] alt_addr_i,
  input  logic              alt_en_i,
  output logic              ack_o,
  output logic              match_o,
  output logic              rd_nwr_o,
  output logic              alt_sel_o
);

  localparam int NSLOT = 2;

  logic [ADDR_W-1:0] rx_addr;
  logic [ADDR_W-1:0] slot_addr [NSLOT];
  logic [NSLOT-1:0]  slot_en;
  logic [NSLOT-1:0]  hits;
  match_res_t        res;

  assign rx_addr      = addr_byte_i[ADDR_W:1];
  assign slot_addr[0] = own_addr_i;
  assign slot_addr[1] = alt_addr_i;
  assign slot_en      = {alt_en_i, 1'b1};

  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
      .rx_addr   (rx_addr),
      .slot_addr (slot_addr[s]),
      .slot_en   (slot_en[s]),
      .hit       (hits[s])
    );
  end

  match_arbiter #(.NSLOT(NSLOT)) arb_i (
    .hits (hits),
    .res  (res)
  );

  match_regs regs_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .vld_i     (addr_vld_i),
    .res_i     (res),
    .dir_i     (addr_byte_i[0]),
    .ack_o     (ack_o),
    .match_o   (match_o),
    .rd_nwr_o  (rd_nwr_o),
    .alt_sel_o (alt_sel_o)
  );

endmodule

// File: rtl/dual_addr_match_chk.sv
module dual_addr_match_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              addr_vld_i,
  input logic [ADDR_W:0]   addr_byte_i,
  input logic [ADDR_W-1:0] own_addr_i,
  input logic [ADDR_W-1:0] alt_addr_i,
  input logic              alt_en_i,
  input logic              ack_o,
  input logic              match_o,
  input logic              rd_nwr_o,
  input logic              alt_sel_o
);

  logic own_eq, alt_eq;
  assign own_eq = addr_byte_i[ADDR_W:1] == own_addr_i;
  assign alt_eq = addr_byte_i[ADDR_W:1] == alt_addr_i;

  assert_primary_ack_R2: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i && own_eq |=> ack_o);

  assert_refuse_R2: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i && !own_eq && (!alt_en_i || !alt_eq) |=> !ack_o);

  assert_alt_ack_R3: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i && alt_en_i && alt_eq |=> ack_o);

  assert_alt_sel_R4: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i && alt_en_i && alt_eq && !own_eq |=> alt_sel_o);

  assert_primary_prio_R5: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i && own_eq |=> !alt_sel_o);

  assert_dir_R6: assert property (@(posedge clk) disable iff (rst)
    addr_vld_i |=> rd_nwr_o == $past(addr_byte_i[0]));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !addr_vld_i |=> !match_o);

  assert_pulse_ack_R7: assert property (@(posedge clk) disable iff (rst)
    match_o |-> ack_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !addr_vld_i && !start_i |=> $stable(ack_o) && $stable(alt_sel_o) && $stable(rd_nwr_o));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    start_i && !addr_vld_i |=> !ack_o && !alt_sel_o && !rd_nwr_o);

endmodule

bind dual_addr_match dual_addr_match_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dual_addr_match_tb_top.sv
module dual_addr_match_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       addr_vld_i = 1'b0;
  logic [7:0] addr_byte_i = 8'h00;
  logic [6:0] own_addr_i = 7'h00;
  logic [6:0] alt_addr_i = 7'h00;
  logic       alt_en_i = 1'b0;
  logic       ack_o, match_o, rd_nwr_o, alt_sel_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_addr_match #(.ADDR_W(7)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_vld_i(addr_vld_i),
    .addr_byte_i(addr_byte_i), .own_addr_i(own_addr_i), .alt_addr_i(alt_addr_i),
    .alt_en_i(alt_en_i), .ack_o(ack_o), .match_o(match_o),
    .rd_nwr_o(rd_nwr_o), .alt_sel_o(alt_sel_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // One strobe with byte b, then a hold cycle, then a START clear.
  task automatic run_byte(input logic [7:0] b);
    logic ph, ah, e_ack, e_sel;
    ph    = (b[7:1] == own_addr_i);
    ah    = alt_en_i && (b[7:1] == alt_addr_i);
    e_ack = ph || ah;
    e_sel = ah && !ph;
    @(negedge clk);
    addr_byte_i = b;
    addr_vld_i  = 1'b1;
    @(negedge clk);
    addr_vld_i  = 1'b0;
    addr_byte_i = ~b;
    chk(alt_en_i ? "R3" : "R2", "ack", ack_o, e_ack);
    chk(e_sel ? "R4" : "R5", "alt_sel", alt_sel_o, e_sel);
    chk("R6", "rd_nwr", rd_nwr_o, b[0]);
    chk("R7", "match pulse", match_o, e_ack);
    @(negedge clk);
    chk("R8", "hold ack", ack_o, e_ack);
    chk("R8", "hold alt_sel", alt_sel_o, e_sel);
    chk("R8", "hold rd_nwr", rd_nwr_o, b[0]);
    chk("R7", "pulse ends", match_o, 1'b0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", "start clears ack", ack_o, 1'b0);
    chk("R8", "start clears alt_sel", alt_sel_o, 1'b0);
    chk("R8", "start clears rd_nwr", rd_nwr_o, 1'b0);
  endtask

  task automatic sweep(input logic [6:0] own, input logic [6:0] alt, input logic en);
    own_addr_i = own;
    alt_addr_i = alt;
    alt_en_i   = en;
    for (int v = 0; v < 256; v++) run_byte(v[7:0]);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset ack", ack_o, 1'b0);
    chk("R1", "reset match", match_o, 1'b0);
    chk("R1", "reset rd_nwr", rd_nwr_o, 1'b0);
    chk("R1", "reset alt_sel", alt_sel_o, 1'b0);
    rst = 1'b0;

    sweep(7'h2A, 7'h55, 1'b0);  // R2: alternate gated off
    sweep(7'h2A, 7'h55, 1'b1);  // R3, R4
    sweep(7'h13, 7'h13, 1'b1);  // R5: equal addresses, primary wins
    sweep(7'h00, 7'h7F, 1'b1);  // boundary values

    // R8: START together with a strobe, the strobe wins
    own_addr_i = 7'h21;
    alt_addr_i = 7'h4C;
    alt_en_i   = 1'b1;
    @(negedge clk);
    addr_byte_i = {7'h4C, 1'b1};
    addr_vld_i  = 1'b1;
    start_i     = 1'b1;
    @(negedge clk);
    addr_vld_i = 1'b0;
    start_i    = 1'b0;
    chk("R8", "strobe over start ack", ack_o, 1'b1);
    chk("R8", "strobe over start alt_sel", alt_sel_o, 1'b1);
    chk("R8", "strobe over start rd_nwr", rd_nwr_o, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule